// File: doc/BRIEF.md
# Automatic Recording Gain Controller

This block steers the 6-bit gain codes of a stereo recording preamplifier from the digital samples that come back out of the converters. Gain codes run from 0 (-12 dB) upward in 0.75 dB steps: code 16 is 0 dB and code 63 is +35.25 dB. Each channel keeps a peak detector over a window of sample strobes. It turns the held peak into a coarse level, which is the bit position of the largest magnitude, and compares that level with a programmed target. Depending on that comparison, it moves the gain by one step when the window closes.

The block has two modes. In level mode the gain rises when the signal is quieter than the target and falls when it is louder, so the recorded level stays roughly constant. In limiter mode the gain only ever falls, and only when the peak goes above the target. Rising steps come at a decay interval and falling steps at an attack interval. Both intervals are counted in sample strobes and double with each step of their 4-bit code. A noise gate stops the gain from rising while the level sits below a threshold, so that silence is not amplified into hiss. A 2-bit enable switches the function on per channel, and a disabled channel keeps its gain.

Top module: `lvl_gain_ctrl`

## Requirements
- R1: After reset both gain outputs are code 16 (0 dB), and both channels start with an empty window (count 0, held peak 0).
- R2: The level of a window is 1 + the index of the highest set bit of the largest sample magnitude seen in that window, including the current sample (0 for silence). Negative samples count by magnitude, and the most negative value gives level SAMPLE_W. The peak is held until the window closes.
- R3: In level mode (lim_mode = 0), when a window closes with level below target_lvl and the gate is not active, the gain rises by one code.
- R4: In both modes, while level exceeds target_lvl, the window closes once its strobe count reaches ATK_BASE << attack_code (default ATK_BASE = 1), and the gain then falls by one code.
- R5: When level does not exceed target_lvl, the window closes once its strobe count reaches DCY_BASE << decay_code (default DCY_BASE = 4). A closed window restarts with count 0 and peak 0.
- R6: Gain never rises above max_gain. If the gain is above max_gain at an enabled strobe, it is loaded with max_gain on that strobe.
- R7: Gain never falls below code 0. A falling step at code 0 leaves the gain at 0.
- R8: In limiter mode (lim_mode = 1), the gain never rises.
- R9: With gate_en = 1 and level below gate_thr, a closing window does not raise the gain.
- R10: chan_en bit 1 enables the left channel and bit 0 the right (00 off, 01 right only, 10 left only, 11 both). A disabled channel holds its gain and its window state.
- R11: Gain outputs change only in the cycle after a cycle with smp_valid = 1, and a rise is always exactly one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | One stereo sample pair present this cycle |
| smp_l | input | SAMPLE_W | Left converter sample, two's complement |
| smp_r | input | SAMPLE_W | Right converter sample, two's complement |
| chan_en | input | 2 | Channel enables: bit 1 left, bit 0 right |
| lim_mode | input | 1 | 0 level mode, 1 limiter mode |
| target_lvl | input | LVL_W | Target level, on the same scale as the measured level |
| max_gain | input | GAIN_W | Highest allowed gain code |
| decay_code | input | 4 | Rise interval code |
| attack_code | input | 4 | Fall interval code |
| gate_en | input | 1 | Noise gate enable |
| gate_thr | input | LVL_W | Noise gate threshold level |
| gain_l | output | GAIN_W | Left preamplifier gain code |
| gain_r | output | GAIN_W | Right preamplifier gain code |

## Verification
Steady quiet tones show the pace of the rising ramp at two decay codes and where the ramp stops at the maximum. Steady loud tones, including the most negative sample, show the falling pace at two attack codes and the floor at code 0. A loud sample placed first in an otherwise quiet window tells a held peak apart from a level taken from the last sample only. The same quiet tone is then replayed under limiter mode, under a gate above and below its level, and under each enable pattern, which separates the three ways a rise is blocked. Finally a sweep over every level from silence to full scale, in both modes and on both signs, is compared sample by sample against an arithmetic model.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  typedef enum logic {
    LGC_LEVEL = 1'b0,
    LGC_LIMIT = 1'b1
  } lgc_mode_e;

  localparam int LGC_CODE_W = 4;
endpackage

// File: rtl/lgc_step_len.sv
module lgc_step_len #(
  parameter int CNT_W = 19,
  parameter int BASE  = 4
) (
  input  logic [lgc_pkg::LGC_CODE_W-1:0] code,
  output logic [CNT_W-1:0]               len
);
  // interval in strobes doubles per code step
  always_comb begin
    len = CNT_W'(BASE) << code;
  end
endmodule

// File: rtl/lgc_peak_meter.sv
module lgc_peak_meter #(
  parameter int SAMPLE_W = 16,
  parameter int LVL_W    = 5
) (
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [SAMPLE_W-1:0] peak_q,
  output logic [SAMPLE_W-1:0] peak_new,
  output logic [LVL_W-1:0]    lvl
);
  logic [SAMPLE_W-1:0] mag;

  // magnitude; most negative value maps to 2^(SAMPLE_W-1) unsigned
  always_comb begin
    if (smp[SAMPLE_W-1]) begin
      mag = ~smp + 1'b1;
    end else begin
      mag = smp;
    end
  end

  always_comb begin
    if (mag > peak_q) begin
      peak_new = mag;
    end else begin
      peak_new = peak_q;
    end
  end

  // level = index of top set bit + 1
  always_comb begin
    lvl = '0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (peak_new[i]) begin
        lvl = LVL_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/lgc_channel.sv
module lgc_channel #(
  parameter int SAMPLE_W   = 16,
  parameter int GAIN_W     = 6,
  parameter int LVL_W      = 5,
  parameter int CNT_W      = 19,
  parameter int RESET_GAIN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                ch_en,
  input  logic                lim_mode,
  input  logic [LVL_W-1:0]    target_lvl,
  input  logic [GAIN_W-1:0]   max_gain,
  input  logic [CNT_W-1:0]    dcy_len,
  input  logic [CNT_W-1:0]    atk_len,
  input  logic                gate_en,
  input  logic [LVL_W-1:0]    gate_thr,
  output logic [GAIN_W-1:0]   gain
);
  import lgc_pkg::*;

  logic [GAIN_W-1:0]   gain_q, gain_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SAMPLE_W-1:0] peak_q, peak_d;
  logic [SAMPLE_W-1:0] peak_new;
  logic [LVL_W-1:0]    lvl;
  logic [CNT_W-1:0]    cnt_inc;
  logic                upd_en;
  logic                over, under, gated;
  logic                end_atk, end_dcy;
  logic                step_up, step_dn;

  lgc_peak_meter #(
    .SAMPLE_W (SAMPLE_W),
    .LVL_W    (LVL_W)
  ) meter_i (
    .smp      (smp),
    .peak_q   (peak_q),
    .peak_new (peak_new),
    .lvl      (lvl)
  );

  assign upd_en  = smp_valid & ch_en;
  assign cnt_inc = cnt_q + 1'b1;

  // window decisions
  always_comb begin
    over    = (lvl > target_lvl);
    under   = (lvl < target_lvl);
    gated   = gate_en & (lvl < gate_thr);
    end_atk = over & (cnt_inc >= atk_len);
    end_dcy = ~over & (cnt_inc >= dcy_len);
    step_dn = end_atk;
    step_up = end_dcy & under & ~gated & (lim_mode == LGC_LEVEL);
  end

  // window state next value
  always_comb begin
    if (end_atk || end_dcy) begin
      cnt_d  = '0;
      peak_d = '0;
    end else begin
      cnt_d  = cnt_inc;
      peak_d = peak_new;
    end
  end

  // gain next value, clamp first
  always_comb begin
    gain_d = gain_q;
    if (gain_q > max_gain) begin
      gain_d = max_gain;
    end else if (step_dn) begin
      if (gain_q != '0) begin
        gain_d = gain_q - 1'b1;
      end
    end else if (step_up) begin
      if (gain_q < max_gain) begin
        gain_d = gain_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_W'(RESET_GAIN);
      cnt_q  <= '0;
      peak_q <= '0;
    end else if (upd_en) begin
      gain_q <= gain_d;
      cnt_q  <= cnt_d;
      peak_q <= peak_d;
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/lvl_gain_ctrl.sv
module lvl_gain_ctrl #(
  parameter int SAMPLE_W   = 16,
  parameter int GAIN_W     = 6,
  parameter int DCY_BASE   = 4,
  parameter int ATK_BASE   = 1,
  parameter int RESET_GAIN = 16,
  localparam int LVL_W     = $clog2(SAMPLE_W + 1),
  localparam int BASE_MAX  = (DCY_BASE > ATK_BASE) ? DCY_BASE : ATK_BASE,
  localparam int CNT_W     = $clog2(BASE_MAX + 1) + (1 << lgc_pkg::LGC_CODE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic [1:0]          chan_en,
  input  logic                lim_mode,
  input  logic [LVL_W-1:0]    target_lvl,
  input  logic [GAIN_W-1:0]   max_gain,
  input  logic [3:0]          decay_code,
  input  logic [3:0]          attack_code,
  input  logic                gate_en,
  input  logic [LVL_W-1:0]    gate_thr,
  output logic [GAIN_W-1:0]   gain_l,
  output logic [GAIN_W-1:0]   gain_r
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [CNT_W-1:0]    dcy_len, atk_len;
  logic [SAMPLE_W-1:0] smp_vec [2];
  logic [GAIN_W-1:0]   gain_vec [2];

  // assert asynchronously, release on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  lgc_step_len #(.CNT_W(CNT_W), .BASE(DCY_BASE)) dcy_len_i (
    .code (decay_code),
    .len  (dcy_len)
  );

  lgc_step_len #(.CNT_W(CNT_W), .BASE(ATK_BASE)) atk_len_i (
    .code (attack_code),
    .len  (atk_len)
  );

  // index 0 left (chan_en[1]), index 1 right (chan_en[0])
  assign smp_vec[0] = smp_l;
  assign smp_vec[1] = smp_r;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    lgc_channel #(
      .SAMPLE_W   (SAMPLE_W),
      .GAIN_W     (GAIN_W),
      .LVL_W      (LVL_W),
      .CNT_W      (CNT_W),
      .RESET_GAIN (RESET_GAIN)
    ) ch_i (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .smp_valid  (smp_valid),
      .smp        (smp_vec[c]),
      .ch_en      (chan_en[1-c]),
      .lim_mode   (lim_mode),
      .target_lvl (target_lvl),
      .max_gain   (max_gain),
      .dcy_len    (dcy_len),
      .atk_len    (atk_len),
      .gate_en    (gate_en),
      .gate_thr   (gate_thr),
      .gain       (gain_vec[c])
    );
  end

  assign gain_l = gain_vec[0];
  assign gain_r = gain_vec[1];
endmodule

// File: rtl/lvl_gain_ctrl_chk.sv
module lvl_gain_ctrl_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [1:0]        chan_en,
  input logic              lim_mode,
  input logic [GAIN_W-1:0] max_gain,
  input logic [GAIN_W-1:0] gain_l,
  input logic [GAIN_W-1:0] gain_r
);
  // R11
  idle_hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain_l));

  // R11
  idle_hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain_r));

  // R10
  off_hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en[1] |=> $stable(gain_l));

  // R10
  off_hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en[0] |=> $stable(gain_r));

  // R6
  rise_cap_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l > $past(gain_l)) |-> (gain_l <= $past(max_gain)));

  // R6
  rise_cap_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_r > $past(gain_r)) |-> (gain_r <= $past(max_gain)));

  // R11
  one_step_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l > $past(gain_l)) |-> (gain_l == $past(gain_l) + 1'b1));

  // R11
  one_step_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_r > $past(gain_r)) |-> (gain_r == $past(gain_r) + 1'b1));

  // R8
  limit_no_rise_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lim_mode) |-> (gain_l <= $past(gain_l)));

  // R8
  limit_no_rise_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lim_mode) |-> (gain_r <= $past(gain_r)));
endmodule

bind lvl_gain_ctrl lvl_gain_ctrl_chk #(.GAIN_W(GAIN_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .chan_en   (chan_en),
  .lim_mode  (lim_mode),
  .max_gain  (max_gain),
  .gain_l    (gain_l),
  .gain_r    (gain_r)
);

// File: tb/lvl_gain_ctrl_tb_top.sv
module lvl_gain_ctrl_tb_top;
  localparam int SW   = 16;
  localparam int GW   = 6;
  localparam int LW   = 5;
  localparam int DCYB = 4;
  localparam int ATKB = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [SW-1:0] smp_l, smp_r;
  logic [1:0]    chan_en;
  logic          lim_mode;
  logic [LW-1:0] target_lvl, gate_thr;
  logic [GW-1:0] max_gain;
  logic [3:0]    decay_code, attack_code;
  logic          gate_en;
  logic [GW-1:0] gain_l, gain_r;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int mg[2], mc[2], mp[2];

  always #2 clk = ~clk;

  lvl_gain_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid),
    .smp_l (smp_l), .smp_r (smp_r), .chan_en (chan_en),
    .lim_mode (lim_mode), .target_lvl (target_lvl), .max_gain (max_gain),
    .decay_code (decay_code), .attack_code (attack_code),
    .gate_en (gate_en), .gate_thr (gate_thr),
    .gain_l (gain_l), .gain_r (gain_r)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(int m);
    int l = 0;
    while ((1 << l) <= m) l++;
    return l;
  endfunction

  // arithmetic reference from the requirements
  task automatic model_ch(int c, int s, bit en);
    int nc, np, lv;
    bit over, up, dn;
    if (!en) return;
    nc = mc[c] + 1;
    np = (s < 0) ? -s : s;
    if (mp[c] > np) np = mp[c];
    lv = lvl_of(np);
    over = lv > int'(target_lvl);
    up = 0; dn = 0;
    if (over && nc >= (ATKB << attack_code)) begin
      dn = 1; mc[c] = 0; mp[c] = 0;
    end else if (!over && nc >= (DCYB << decay_code)) begin
      up = (lv < int'(target_lvl)) && !lim_mode &&
           !(gate_en && lv < int'(gate_thr));
      mc[c] = 0; mp[c] = 0;
    end else begin
      mc[c] = nc; mp[c] = np;
    end
    if (mg[c] > int'(max_gain)) mg[c] = int'(max_gain);
    else if (dn && mg[c] > 0) mg[c]--;
    else if (up && mg[c] < int'(max_gain)) mg[c]++;
  endtask

  task automatic put(string req, int l, int r);
    @(negedge clk);
    smp_l = SW'(l); smp_r = SW'(r); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    model_ch(0, l, chan_en[1]);
    model_ch(1, r, chan_en[0]);
    chk(req, int'(gain_l), mg[0]);
    chk(req, int'(gain_r), mg[1]);
  endtask

  task automatic run(string req, int n, int l, int r);
    for (int i = 0; i < n; i++) put(req, l, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_l = '0; smp_r = '0;
    chan_en = 2'b11; lim_mode = 1'b0; target_lvl = 5'd10; max_gain = 6'd63;
    decay_code = 4'd0; attack_code = 4'd0; gate_en = 1'b0; gate_thr = '0;
    for (int c = 0; c < 2; c++) begin mg[c] = 16; mc[c] = 0; mp[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", int'(gain_l), 16);
    chk("R1", int'(gain_r), 16);

    // R3 / R5: quiet tone, window 4 strobes
    run("R3", 20, 8, -8);
    chk("R3", int'(gain_l), 21);
    decay_code = 4'd2;                      // window 16 strobes
    run("R5", 32, 8, -8);
    chk("R5", int'(gain_r), 23);

    // R6: ceiling, then lowered ceiling clamps
    decay_code = 4'd0; max_gain = 6'd24;
    run("R6", 12, 8, 8);
    chk("R6", int'(gain_l), 24);
    max_gain = 6'd20;
    put("R6", 8, 8);
    chk("R6", int'(gain_r), 20);

    // R4 / R7 / R2: loud tone and most negative value, floor at 0
    run("R7", 25, 30000, -32768);
    chk("R7", int'(gain_l), 0);
    chk("R7", int'(gain_r), 0);
    run("R3", 80, 8, 8);
    attack_code = 4'd2;                     // fall every 4 strobes
    run("R4", 8, 20000, 20000);
    chk("R4", int'(gain_l), 18);

    // R2: loud sample first in window is held, no rise
    put("R2", 512, 512); put("R2", 8, 8); put("R2", 8, 8); put("R2", 8, 8);
    chk("R2", int'(gain_l), 18);

    // R8: limiter never rises, still falls
    lim_mode = 1'b1; attack_code = 4'd0;
    run("R8", 20, 8, 8);
    chk("R8", int'(gain_l), 18);
    run("R8", 3, 20000, 20000);
    chk("R8", int'(gain_r), 15);
    lim_mode = 1'b0;

    // R9: gate above signal level blocks rise, below does not
    gate_en = 1'b1; gate_thr = 5'd6;
    run("R9", 20, 8, 8);
    chk("R9", int'(gain_l), 15);
    gate_thr = 5'd3;
    run("R9", 8, 8, 8);
    chk("R9", int'(gain_l), 17);
    gate_en = 1'b0;

    // R10: enable patterns
    chan_en = 2'b01;
    run("R10", 8, 8, 8);
    chk("R10", int'(gain_l), 17);
    chk("R10", int'(gain_r), 19);
    chan_en = 2'b10;
    run("R10", 4, 30000, 30000);
    chk("R10", int'(gain_r), 19);
    chan_en = 2'b00;
    run("R10", 6, 8, 30000);
    chk("R10", int'(gain_l), 13);
    chan_en = 2'b11;

    // R2 / R11: sweep every level, both modes, both signs
    max_gain = 6'd40;
    for (int m = 0; m < 2; m++) begin
      lim_mode = m[0];
      for (int k = 0; k <= SW; k++) begin
        int a;
        a = (k == 0) ? 0 : (1 << (k - 1));
        if (k == SW) run("R2", 9, -a, -a);
        else run("R11", 9, a, -a);
      end
    end

    finish_run();
  end
endmodule